// File: doc/BRIEF.md
# Write-through cache access controller

This controller sits between a processor's request port and a shared internal bus. Every request is sorted by its address into one of two kinds. A cacheable access is looked up in a small direct-mapped store. A bypass access covers the uncached alias window and the on-chip peripheral space. Both kinds spend one cycle on lookup or decode before anything else happens.

A cacheable read that hits returns its data from the store without using the bus. A cacheable read that misses refills the whole 16-byte line with four longword bus reads, then answers the processor. A bypass read makes a single bus read at the address and size of the request, except that instruction fetches are widened to an aligned longword.

Writes always go to the bus. A cacheable write also patches the line when it hits, and never allocates a line when it misses. The processor is released from a write as soon as the bus is granted. It does not wait for the target to acknowledge. The posted write then drains on the bus before the controller accepts another request.

Top module: `wt_cache_ctl`

## Requirements
- R1: After reset `cpu_ready`, `bus_req` and `bus_valid` are low and every line is invalid, so the first cacheable read misses.
- R2: A cacheable read that hits raises `cpu_ready` in the cycle after the request is accepted, with the stored longword, and makes no bus transfer.
- R3: A cacheable read miss makes exactly four bus reads at line offsets 0, 4, 8 and 12 in that order, after which the line is valid.
- R4: Every fill read is a longword (size code 2) at a 4-byte aligned address, even when the missing request was a byte, a word or a fetch at a 4n+2 address.
- R5: After a miss, `cpu_ready` rises one cycle after the fourth fill beat completes, carrying the whole longword that holds the requested address.
- R6: An address with bit 29 set, or with bits 31:28 equal to 0xF, bypasses the cache. It makes one bus read with the request address and size (0 byte, 1 word, 2 longword) and allocates nothing.
- R7: An instruction fetch (`cpu_ifetch`) in bypass space reads a longword with address bits 1:0 cleared.
- R8: A bypass read has no bus transfer in its decode cycle. `cpu_ready` rises in the cycle of the bus acknowledge, carrying `bus_rdata`.
- R9: Every write makes one bus write with the request address, size and data. A cacheable hit replaces only the enabled byte lanes of the stored word. Lane n is bits 8n+7:8n; a byte uses lane addr[1:0], and a word uses lanes 1:0 or 3:2 selected by addr[1]. A miss leaves the cache unchanged.
- R10: If `bus_gnt` is high in a write's decode cycle, `cpu_ready` rises in that cycle, before the write is acknowledged.
- R11: Otherwise the write's `cpu_ready` rises in the first later cycle in which `bus_gnt` is high.
- R12: No new request is accepted until the outstanding bus operation, including a posted write, has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Request present; held with stable fields until `cpu_ready` |
| cpu_we | input | 1 | Write request |
| cpu_ifetch | input | 1 | Instruction fetch |
| cpu_size | input | 2 | 0 byte, 1 word, 2 longword |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data on its byte lanes |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read longword, valid with `cpu_ready` |
| bus_req | output | 1 | Bus wanted |
| bus_gnt | input | 1 | Bus owned by this controller |
| bus_valid | output | 1 | Transfer presented |
| bus_we | output | 1 | Transfer is a write |
| bus_size | output | 2 | Transfer size code |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The embedded properties assume a well-behaved processor and a well-behaved target. The processor keeps its request fields stable until `cpu_ready`. The target acknowledges only while `bus_valid` is high. The bench's processor driver drops the request in the cycle it sees `cpu_ready`. Its bus responder acknowledges only presented transfers, after a chosen or random delay, while the grant toggles randomly or is held low for a set number of cycles. Addresses come from a small pool of tags and indices so that hits, conflict evictions and write hits occur often.

// File: rtl/wt_cache_ctl.sv
module wt_cache_ctl #(
  parameter int          LINES      = 64,
  parameter int          THRU_BIT   = 29,
  parameter logic [3:0]  PERIPH_NIB = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic        cpu_ifetch,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        bus_valid,
  output logic        bus_we,
  output logic [1:0]  bus_size,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = 32 - 4 - IDX_W;
  localparam int WORDS = LINES * 4;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FILL, S_RESP, S_BRD, S_WR} st_t;

  st_t         st;
  logic        r_we, r_if, wdone;
  logic [1:0]  r_size, beat;
  logic [31:0] r_addr, r_wdata;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [31:0]      data_q [WORDS];

  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [IDX_W+1:0]   widx, fidx;
  logic               thru, hit, rd_hit, beat_done, on_bus;
  logic [3:0]         wr_be;

  assign idx    = r_addr[4 +: IDX_W];
  assign tag    = r_addr[31 -: TAG_W];
  assign widx   = {idx, r_addr[3:2]};
  assign fidx   = {idx, beat};
  assign thru   = r_addr[THRU_BIT] || (r_addr[31:28] == PERIPH_NIB);
  assign hit    = !thru && valid_q[idx] && (tag_q[idx] == tag);
  assign rd_hit = (st == S_LOOK) && !r_we && hit;
  assign wr_be  = (r_size == 2'd0) ? (4'b0001 << r_addr[1:0]) :
                  (r_size == 2'd1) ? (r_addr[1] ? 4'b1100 : 4'b0011) : 4'b1111;

  assign on_bus    = (st == S_FILL) || (st == S_BRD) || (st == S_WR);
  assign bus_req   = on_bus || ((st == S_LOOK) && !rd_hit);
  assign bus_valid = on_bus && bus_gnt;
  assign beat_done = bus_valid && bus_ack;
  assign bus_we    = (st == S_WR);
  assign bus_wdata = r_wdata;
  assign bus_size  = (st == S_FILL || (st == S_BRD && r_if)) ? 2'd2 : r_size;
  assign bus_addr  = (st == S_FILL) ? {r_addr[31:4], beat, 2'b00} :
                     (st == S_BRD && r_if) ? {r_addr[31:2], 2'b00} : r_addr;

  assign cpu_ready = rd_hit
                  || ((st == S_LOOK) && r_we && bus_gnt)
                  || (st == S_RESP)
                  || ((st == S_BRD) && beat_done)
                  || ((st == S_WR) && bus_gnt && !wdone);
  assign cpu_rdata = (st == S_BRD) ? bus_rdata : data_q[widx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_we    <= 1'b0;
      r_if    <= 1'b0;
      r_size  <= 2'd0;
      r_addr  <= '0;
      r_wdata <= '0;
      beat    <= 2'd0;
      wdone   <= 1'b0;
      valid_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          r_we    <= cpu_we;
          r_if    <= cpu_ifetch;
          r_size  <= cpu_size;
          r_addr  <= cpu_addr;
          r_wdata <= cpu_wdata;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (r_we) begin
            wdone <= bus_gnt;
            st    <= S_WR;
          end else if (thru) begin
            st <= S_BRD;
          end else if (hit) begin
            st <= S_IDLE;
          end else begin
            beat         <= 2'd0;
            valid_q[idx] <= 1'b0;
            st           <= S_FILL;
          end
        end
        S_FILL: if (beat_done) begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            valid_q[idx] <= 1'b1;
            st           <= S_RESP;
          end
        end
        S_RESP: st <= S_IDLE;
        S_BRD:  if (beat_done) st <= S_IDLE;
        S_WR: begin
          if (bus_gnt) wdone <= 1'b1;
          if (beat_done) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && beat_done) begin
      data_q[fidx] <= bus_rdata;
      if (beat == 2'd3) tag_q[idx] <= tag;
    end
    if (st == S_LOOK && r_we && hit) begin
      for (int l = 0; l < 4; l++)
        if (wr_be[l]) data_q[widx][8*l +: 8] <= r_wdata[8*l +: 8];
    end
  end

  p_accept_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !cpu_ready);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_fill_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && !bus_addr[THRU_BIT] && bus_addr[31:28] != PERIPH_NIB)
      |-> (bus_size == 2'd2 && bus_addr[1:0] == 2'b00));

  p_fill_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !bus_we && !bus_addr[THRU_BIT] && bus_addr[31:28] != PERIPH_NIB
     && bus_addr[3:2] != 2'd3)
      |=> (bus_addr[3:2] == $past(bus_addr[3:2]) + 2'd1 && bus_addr[31:4] == $past(bus_addr[31:4])));

  p_ifetch_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && st == S_BRD && r_if) |-> (bus_size == 2'd2 && bus_addr[1:0] == 2'b00));

  p_hold_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(r_addr));

  p_hit_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && cpu_ready) |=> !bus_valid);
endmodule

// File: tb/tb_wt_cache_ctl.sv
`timescale 1ns/1ps
module tb_wt_cache_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_ifetch = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_valid, bus_we;
  logic        bus_gnt = 1'b1, bus_ack = 1'b0;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;

  wt_cache_ctl dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc_g = 0, gnt_low = 0, fix_dly = 0, cur_dly = 0, wcnt = 0;
  bit rnd_gnt = 0, rnd_dly = 0;
  logic [31:0] mem [logic [29:0]];
  logic [31:0] b_addr [8];
  logic [31:0] b_wd   [8];
  logic [1:0]  b_sz   [8];
  logic        b_we   [8];
  int          b_cyc  [8];
  int          beat_n = 0;
  bit          mv [64];
  logic [21:0] mt [64];
  int  last_cyc, last_fg, rdy_cg, beats_at_rdy;
  bit  v_at1;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [3:0] lanes(input logic [1:0] s, input logic [1:0] lo);
    case (s)
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    if (mem.exists(a[31:2])) return mem[a[31:2]];
    return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h3C3C_0F0F;
  endfunction

  function automatic void model_wr(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    logic [31:0] w = model_rd(a);
    logic [3:0]  m = lanes(s, a[1:0]);
    for (int l = 0; l < 4; l++) if (m[l]) w[8*l +: 8] = d[8*l +: 8];
    mem[a[31:2]] = w;
  endfunction

  function automatic bit is_thru(input logic [31:0] a);
    return a[29] || a[31:28] == 4'hF;
  endfunction

  always @(negedge clk) begin
    cyc_g++;
    if (gnt_low > 0) begin bus_gnt = 1'b0; gnt_low--; end
    else bus_gnt = rnd_gnt ? ($urandom % 4 != 0) : 1'b1;
    #1;
    if (bus_valid && wcnt >= cur_dly) begin
      bus_ack   = 1'b1;
      bus_rdata = model_rd(bus_addr);
      if (beat_n < 8) begin
        b_addr[beat_n] = bus_addr; b_wd[beat_n] = bus_wdata;
        b_sz[beat_n] = bus_size; b_we[beat_n] = bus_we; b_cyc[beat_n] = cyc_g;
      end
      beat_n++;
      if (bus_we) model_wr(bus_addr, bus_size, bus_wdata);
      wcnt    = 0;
      cur_dly = rnd_dly ? int'($urandom % 3) : fix_dly;
    end else begin
      bus_ack = 1'b0;
      if (bus_valid) wcnt++;
    end
  end

  task automatic acc(input bit we, input bit ifc, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] wd, input bit drain, output logic [31:0] rd);
    int cyc = 0, fg = -1;
    if (drain) begin
      @(negedge clk); #2;
      while (bus_req) begin @(negedge clk); #2; end
    end
    beat_n = 0; v_at1 = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_ifetch = ifc; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    do begin
      @(negedge clk); #2;
      cyc++;
      if (fg < 0 && bus_gnt) fg = cyc;
      if (cyc == 1 && bus_valid) v_at1 = 1;
    end while (!cpu_ready && cyc < 500);
    rd = cpu_rdata; rdy_cg = cyc_g; beats_at_rdy = beat_n;
    last_cyc = cyc; last_fg = fg;
    cpu_req = 1'b0;
  endtask

  task automatic op(input bit we, input bit ifc, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    logic [31:0] rd, exp, ea;
    logic [1:0]  es;
    logic [5:0]  ix = a[9:4];
    logic [21:0] tg = a[31:10];
    exp = model_rd(a);
    acc(we, ifc, sz, a, wd, 1'b1, rd);
    if (we) begin
      chk(last_cyc == last_fg, "R10 R11 write ready on first granted cycle", last_cyc, last_fg);
      @(negedge clk); #2;
      while (bus_req) begin @(negedge clk); #2; end
      chk(beat_n == 1 && b_we[0] && b_addr[0] == a && b_sz[0] == sz && b_wd[0] == wd,
          "R9 write bus transfer", b_addr[0], a);
    end else if (is_thru(a)) begin
      ea = ifc ? {a[31:2], 2'b00} : a;
      es = ifc ? 2'd2 : sz;
      chk(beat_n == 1 && !b_we[0], "R6 single bypass read", beat_n, 1);
      chk(b_addr[0] == ea, "R6 R7 bypass address", b_addr[0], ea);
      chk(b_sz[0] == es, "R6 R7 bypass size", b_sz[0], es);
      chk(!v_at1, "R8 no transfer in decode cycle", v_at1, 0);
      chk(rdy_cg == b_cyc[0], "R8 ready with acknowledge", rdy_cg, b_cyc[0]);
      chk(rd == exp, "R8 bypass data", rd, exp);
    end else if (mv[ix] && mt[ix] == tg) begin
      chk(last_cyc == 1, "R2 hit latency", last_cyc, 1);
      chk(beat_n == 0, "R2 hit uses no bus", beat_n, 0);
      chk(rd == exp, "R2 hit data", rd, exp);
    end else begin
      chk(beat_n == 4, "R3 four fill beats", beat_n, 4);
      for (int k = 0; k < 4 && k < beat_n; k++) begin
        chk(b_addr[k] == {a[31:4], 2'(k), 2'b00}, "R3 fill order", b_addr[k], {a[31:4], 2'(k), 2'b00});
        chk(b_sz[k] == 2'd2 && !b_we[k], "R4 fill longword", b_sz[k], 2);
      end
      chk(rdy_cg == b_cyc[3] + 1, "R5 ready after last beat", rdy_cg, b_cyc[3] + 1);
      chk(rd == exp, "R5 fill data", rd, exp);
      mv[ix] = 1; mt[ix] = tg;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R12 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mv[i] = 0;
    repeat (4) @(negedge clk);
    #2;
    chk(!cpu_ready, "R1 ready low in reset", cpu_ready, 0);
    chk(!bus_req, "R1 no bus request in reset", bus_req, 0);
    chk(!bus_valid, "R1 no transfer in reset", bus_valid, 0);
    rst_n = 1'b1;

    op(0, 0, 2'd2, 32'h0000_0104, 0);
    chk(beat_n == 4, "R1 first read misses", beat_n, 4);
    op(0, 0, 2'd0, 32'h0000_0109, 0);
    op(0, 1, 2'd1, 32'h0000_0232, 0);
    op(0, 1, 2'd1, 32'h2000_0232, 0);
    op(0, 0, 2'd0, 32'hF000_0013, 0);
    op(0, 0, 2'd1, 32'h2000_0106, 0);
    op(0, 0, 2'd1, 32'h2000_0106, 0);
    op(1, 0, 2'd0, 32'h0000_0105, 32'hAABB_CCDD);
    op(1, 0, 2'd1, 32'h0000_010A, 32'h1122_3344);
    op(0, 0, 2'd2, 32'h0000_0108, 0);
    op(0, 0, 2'd2, 32'h0000_0104, 0);
    op(1, 0, 2'd2, 32'h0000_0340, 32'h5555_AAAA);
    op(0, 0, 2'd2, 32'h0000_0340, 0);
    chk(beat_n == 4, "R9 write miss did not allocate", beat_n, 4);
    op(0, 0, 2'd2, 32'h0000_0504, 0);
    op(0, 0, 2'd2, 32'h0000_0104, 0);

    fix_dly = 5;
    acc(1, 0, 2'd2, 32'h2000_0400, 32'hCAFE_0001, 1'b1, rd);
    chk(last_cyc == 1, "R10 early write ready", last_cyc, 1);
    chk(beats_at_rdy == 0, "R10 ready before acknowledge", beats_at_rdy, 0);
    acc(0, 0, 2'd2, 32'h0000_0104, 0, 1'b0, rd);
    chk(beat_n == 1 && b_we[0], "R12 posted write drained first", beat_n, 1);
    chk(rdy_cg == b_cyc[0] + 2, "R12 next request waits for acknowledge", rdy_cg, b_cyc[0] + 2);
    chk(rd == model_rd(32'h0000_0104), "R12 held request data", rd, model_rd(32'h0000_0104));
    fix_dly = 0;

    gnt_low = 4;
    op(1, 0, 2'd2, 32'h0000_0110, 32'h0BAD_F00D);
    chk(last_cyc == 4, "R11 write ready waits for grant", last_cyc, 4);
    op(0, 0, 2'd2, 32'h0000_0110, 0);

    rnd_gnt = 1; rnd_dly = 1;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      bit we, ifc;
      int kind = int'($urandom % 6);
      a = (($urandom % 2) << 10) | (($urandom % 4) << 4) | (($urandom % 4) << 2);
      if (kind == 4) a |= 32'h2000_0000;
      if (kind == 5) a |= 32'hF000_0000;
      we  = ($urandom % 3 == 0);
      ifc = !we && ($urandom % 4 == 0);
      sz  = 2'($urandom % 3);
      if (ifc) sz = ($urandom % 2 != 0) ? 2'd1 : 2'd2;
      if (sz == 2'd1) a[1:0] = {1'($urandom % 2), 1'b0};
      else if (sz == 2'd0) a[1:0] = 2'($urandom % 4);
      op(we, ifc, sz, a, $urandom);
    end
    finish_run();
  end
endmodule